// File: doc/BRIEF.md
# Filtered Event Statistics Counter with Periodic Frame Dump

This block watches a stream of interconnect transaction events and turns it into one running statistic. Each event presents read, write and error flags, an 8-bit initiator address and three 12-bit measurements: length, pressure and latency. A mask/compare filter qualifies the flags and address. A min/max window qualifies a chosen measurement. A 4-bit operation code picks the rule that updates a saturating counter. Other rules count the AND or OR of external filter lines, the number of request or response events asserted this cycle, or one selected external event line.

The counter is read out as a frame, a one-cycle valid pulse carrying the counter value. A frame is produced every PERIOD cycles while collection runs, or once for each software send command in manual mode. The counter clears atomically in the cycle of the dump and restarts from that cycle's own increment, so no event is lost or counted twice. Configuration uses a simple word-addressed write/read port.

Top module: `stat_tally`

## Requirements
- R1: After reset every configuration register reads 0 and frame_valid is 0. A word written to a register reads back through cfg_rdata. Registers: CTRL at 0 (bit0 run, bit1 manual, bit2 filter global enable, bit3 filter stage enable), OPS at 1 (bits 3:0 operation, 5:4 info select, bits 8 and up external event select), PERIOD at 2, SEND at 3 (bit0), MASK at 4 and COMPARE at 5 (bit0 read, bit1 write, bit2 error, bits 15:8 address), WINDOW at 6 (bits 11:0 min, 27:16 max).
- R2: With operation 0 the counter gains 1 for a valid event whose masked fields equal the compare value. Bits with a mask of 0 have no effect.
- R3: The filter hits only when both the global enable and the stage enable are 1.
- R4: With operation 1 the counter gains 1 when min <= info <= max, bounds included. Info select 0 picks length, 1 picks pressure and 2 picks latency.
- R5: With operation 2 the counter adds the selected info value of each valid event.
- R6: Operation 3 adds 1 when all external filter lines are high. Operation 4 adds 1 when any of them is high.
- R7: Operations 5, 6 and 7 add the number of asserted request lines, response lines, or both together.
- R8: Operation 8 adds 1 when the external event line chosen by the select field is high.
- R9: With run=1, manual=0 and PERIOD=P>0, a frame is emitted every P cycles. With PERIOD=0 no periodic frame occurs.
- R10: A frame carries the counter value held before the dump. The counter then restarts from that cycle's increment.
- R11: With manual=1 periodic frames stop. Writing 1 to SEND produces exactly one frame. SEND reads back 0 afterwards.
- R12: The counter saturates at its all-ones value and never wraps.
- R13: With run=0 the counter does not accumulate, and a dump leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| ev_valid | input | 1 | Transaction event present |
| ev_rd | input | 1 | Event is a read |
| ev_wr | input | 1 | Event is a write |
| ev_err | input | 1 | Event carries an error |
| ev_mst | input | 8 | Initiator address |
| ev_len | input | INFO_W | Length measurement |
| ev_press | input | INFO_W | Pressure measurement |
| ev_lat | input | INFO_W | Latency measurement |
| ext_flt | input | NFLT | External filter hit lines |
| req_evt | input | NREQ | Request event hit lines |
| rsp_evt | input | NRSP | Response event hit lines |
| ext_evt | input | NEXT | External event lines |
| frame_valid | output | 1 | One-cycle frame strobe |
| frame_data | output | CNT_W | Counter value in the frame |

## Verification
A table of single-cycle events is run through every operation code. Each code gets one pattern that must count and one that must not. Address patterns differ only in masked or in unmasked bits, which separates a correct mask from an ignored one. Measurements are placed on the window bounds and one step past them, and the same values are sent on the other measurement inputs to show which one the info select picks. Popcount patterns use different request and response counts, so the three sum operations give different results. Directed runs cover the dump period, a period of zero, two back-to-back manual sends that show the restart-from-increment rule, run disabled, and saturation.

// File: rtl/stat_tally_pkg.sv
// Shared definitions for the statistics counter: operation codes,
// register word indices and the filtered field layout.
package stat_tally_pkg;

    typedef enum logic [3:0] {
        OP_FLT  = 4'd0,
        OP_WIN  = 4'd1,
        OP_ADD  = 4'd2,
        OP_ALL  = 4'd3,
        OP_ANY  = 4'd4,
        OP_REQ  = 4'd5,
        OP_RSP  = 4'd6,
        OP_BOTH = 4'd7,
        OP_EXT  = 4'd8
    } op_e;

    localparam logic [3:0] A_CTRL   = 4'd0;
    localparam logic [3:0] A_OPS    = 4'd1;
    localparam logic [3:0] A_PERIOD = 4'd2;
    localparam logic [3:0] A_SEND   = 4'd3;
    localparam logic [3:0] A_MASK   = 4'd4;
    localparam logic [3:0] A_CMP    = 4'd5;
    localparam logic [3:0] A_WIN    = 4'd6;

    typedef struct packed {
        logic [7:0] mst;
        logic       err;
        logic       wr;
        logic       rd;
    } fld_t;

endpackage

// File: rtl/stat_tally_regs.sv
// Configuration register file.
// Assumes INFO_W <= 16 and PER_W <= 32. SEND is a one-cycle strobe that
// clears itself on the next clock.
module stat_tally_regs
    import stat_tally_pkg::*;
#(
    parameter int INFO_W = 12,
    parameter int PER_W  = 16,
    parameter int ESW    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [3:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              run,
    output logic              manual,
    output logic              gen,
    output logic              sen,
    output logic [3:0]        op,
    output logic [1:0]        isel,
    output logic [ESW-1:0]    ext_sel,
    output logic [PER_W-1:0]  period,
    output logic              send_q,
    output fld_t              mask,
    output fld_t              cmp,
    output logic [INFO_W-1:0] wmin,
    output logic [INFO_W-1:0] wmax
);

    // Register writes; send_q drops back to 0 one cycle after being set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            manual  <= 1'b0;
            gen     <= 1'b0;
            sen     <= 1'b0;
            op      <= '0;
            isel    <= '0;
            ext_sel <= '0;
            period  <= '0;
            send_q  <= 1'b0;
            mask    <= '0;
            cmp     <= '0;
            wmin    <= '0;
            wmax    <= '0;
        end else begin
            send_q <= 1'b0;
            if (we) begin
                case (addr)
                    A_CTRL: begin
                        run    <= wdata[0];
                        manual <= wdata[1];
                        gen    <= wdata[2];
                        sen    <= wdata[3];
                    end
                    A_OPS: begin
                        op      <= wdata[3:0];
                        isel    <= wdata[5:4];
                        ext_sel <= wdata[8 +: ESW];
                    end
                    A_PERIOD: period <= wdata[PER_W-1:0];
                    A_SEND:   send_q <= wdata[0];
                    A_MASK:   mask   <= {wdata[15:8], wdata[2:0]};
                    A_CMP:    cmp    <= {wdata[15:8], wdata[2:0]};
                    A_WIN: begin
                        wmin <= wdata[INFO_W-1:0];
                        wmax <= wdata[16 +: INFO_W];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read mux over the same layout as the writes.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:   rdata[3:0] = {sen, gen, manual, run};
            A_OPS: begin
                rdata[3:0]      = op;
                rdata[5:4]      = isel;
                rdata[8 +: ESW] = ext_sel;
            end
            A_PERIOD: rdata[PER_W-1:0] = period;
            A_SEND:   rdata[0] = send_q;
            A_MASK:   rdata[15:0] = {mask.mst, 5'd0, mask.err, mask.wr, mask.rd};
            A_CMP:    rdata[15:0] = {cmp.mst, 5'd0, cmp.err, cmp.wr, cmp.rd};
            A_WIN: begin
                rdata[INFO_W-1:0]  = wmin;
                rdata[16 +: INFO_W] = wmax;
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/stat_tally_qual.sv
// Event qualification: the mask/compare filter, the min/max window and
// the per-cycle increment chosen by the operation code.
// Purely combinational. Unknown operation codes give an increment of 0.
module stat_tally_qual
    import stat_tally_pkg::*;
#(
    parameter int INFO_W = 12,
    parameter int NFLT   = 4,
    parameter int NREQ   = 4,
    parameter int NRSP   = 4,
    parameter int NEXT   = 8,
    parameter int ESW    = 3,
    parameter int INC_W  = 13
) (
    input  logic              ev_valid,
    input  logic              ev_rd,
    input  logic              ev_wr,
    input  logic              ev_err,
    input  logic [7:0]        ev_mst,
    input  logic [INFO_W-1:0] ev_len,
    input  logic [INFO_W-1:0] ev_press,
    input  logic [INFO_W-1:0] ev_lat,
    input  logic [NFLT-1:0]   ext_flt,
    input  logic [NREQ-1:0]   req_evt,
    input  logic [NRSP-1:0]   rsp_evt,
    input  logic [NEXT-1:0]   ext_evt,
    input  logic              gen,
    input  logic              sen,
    input  logic [3:0]        op,
    input  logic [1:0]        isel,
    input  logic [ESW-1:0]    ext_sel,
    input  fld_t              mask,
    input  fld_t              cmp,
    input  logic [INFO_W-1:0] wmin,
    input  logic [INFO_W-1:0] wmax,
    output logic [INC_W-1:0]  inc
);

    fld_t              ev_f;
    logic              flt_hit;
    logic              win_hit;
    logic [INFO_W-1:0] info;
    logic [INC_W-1:0]  n_req;
    logic [INC_W-1:0]  n_rsp;

    // Filter: every masked bit must equal its compare bit.
    always_comb begin
        ev_f    = '{mst: ev_mst, err: ev_err, wr: ev_wr, rd: ev_rd};
        flt_hit = ev_valid && gen && sen && (((ev_f ^ cmp) & mask) == '0);
    end

    // Measurement select and inclusive window compare.
    always_comb begin
        case (isel)
            2'd0:    info = ev_len;
            2'd1:    info = ev_press;
            2'd2:    info = ev_lat;
            default: info = '0;
        endcase
        win_hit = ev_valid && (info >= wmin) && (info <= wmax);
    end

    // Population counts of the request and response hit lines.
    always_comb begin
        n_req = '0;
        n_rsp = '0;
        for (int i = 0; i < NREQ; i++) n_req = n_req + INC_W'(req_evt[i]);
        for (int j = 0; j < NRSP; j++) n_rsp = n_rsp + INC_W'(rsp_evt[j]);
    end

    // Increment chosen by the operation code.
    always_comb begin
        case (op)
            OP_FLT:  inc = INC_W'(flt_hit);
            OP_WIN:  inc = INC_W'(win_hit);
            OP_ADD:  inc = ev_valid ? INC_W'(info) : '0;
            OP_ALL:  inc = INC_W'(&ext_flt);
            OP_ANY:  inc = INC_W'(|ext_flt);
            OP_REQ:  inc = n_req;
            OP_RSP:  inc = n_rsp;
            OP_BOTH: inc = n_req + n_rsp;
            OP_EXT:  inc = INC_W'(ext_evt[ext_sel]);
            default: inc = '0;
        endcase
    end

endmodule

// File: rtl/stat_tally_accum.sv
// Saturating accumulator with dump timer.
// A dump fires either every PERIOD cycles (run set, manual clear,
// PERIOD non-zero) or on the send strobe in manual mode. On a dump the
// held value goes out as a frame and the counter reloads with this
// cycle's increment. Assumes CNT_W >= INC_W.
module stat_tally_accum #(
    parameter int CNT_W = 32,
    parameter int PER_W = 16,
    parameter int INC_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             manual,
    input  logic [PER_W-1:0] period,
    input  logic             send_q,
    input  logic [INC_W-1:0] inc,
    output logic             dump_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             frame_valid,
    output logic [CNT_W-1:0] frame_data
);

    logic [PER_W-1:0] tmr;
    logic             periodic;
    logic [CNT_W-1:0] inc_x;
    logic [CNT_W:0]   sum;

    // Dump decision and saturating next value.
    always_comb begin
        periodic = run && !manual && (period != '0);
        dump_o   = (periodic && (tmr >= period - PER_W'(1))) || (manual && send_q);
        inc_x    = {{(CNT_W-INC_W){1'b0}}, inc};
        sum      = {1'b0, cnt_o} + {1'b0, inc_x};
    end

    // Period timer, restarted at every dump and held at 0 when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !periodic || dump_o) tmr <= '0;
        else                               tmr <= tmr + PER_W'(1);
    end

    // Counter update and frame register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o       <= '0;
            frame_valid <= 1'b0;
            frame_data  <= '0;
        end else begin
            frame_valid <= dump_o;
            if (dump_o) begin
                frame_data <= cnt_o;
                cnt_o      <= run ? inc_x : '0;
            end else if (run) begin
                cnt_o <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/stat_tally.sv
// Top level of the filtered statistics counter: register file, event
// qualification and accumulator wired together.
module stat_tally
    import stat_tally_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int INFO_W = 12,
    parameter int PER_W  = 16,
    parameter int NFLT   = 4,
    parameter int NREQ   = 4,
    parameter int NRSP   = 4,
    parameter int NEXT   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              ev_valid,
    input  logic              ev_rd,
    input  logic              ev_wr,
    input  logic              ev_err,
    input  logic [7:0]        ev_mst,
    input  logic [INFO_W-1:0] ev_len,
    input  logic [INFO_W-1:0] ev_press,
    input  logic [INFO_W-1:0] ev_lat,
    input  logic [NFLT-1:0]   ext_flt,
    input  logic [NREQ-1:0]   req_evt,
    input  logic [NRSP-1:0]   rsp_evt,
    input  logic [NEXT-1:0]   ext_evt,
    output logic              frame_valid,
    output logic [CNT_W-1:0]  frame_data
);

    localparam int ESW   = (NEXT > 1) ? $clog2(NEXT) : 1;
    localparam int INC_W = INFO_W + 1;

    logic              run_q, manual_q, gen_q, sen_q, send_q, dump_w;
    logic [3:0]        op_q;
    logic [1:0]        isel_q;
    logic [ESW-1:0]    ext_sel_q;
    logic [PER_W-1:0]  period_q;
    fld_t              mask_q, cmp_q;
    logic [INFO_W-1:0] wmin_q, wmax_q;
    logic [INC_W-1:0]  inc_w;
    logic [CNT_W-1:0]  cnt_w;

    stat_tally_regs #(.INFO_W(INFO_W), .PER_W(PER_W), .ESW(ESW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .run(run_q), .manual(manual_q),
        .gen(gen_q), .sen(sen_q), .op(op_q), .isel(isel_q),
        .ext_sel(ext_sel_q), .period(period_q), .send_q(send_q),
        .mask(mask_q), .cmp(cmp_q), .wmin(wmin_q), .wmax(wmax_q)
    );

    stat_tally_qual #(
        .INFO_W(INFO_W), .NFLT(NFLT), .NREQ(NREQ), .NRSP(NRSP),
        .NEXT(NEXT), .ESW(ESW), .INC_W(INC_W)
    ) u_qual (
        .ev_valid(ev_valid), .ev_rd(ev_rd), .ev_wr(ev_wr), .ev_err(ev_err),
        .ev_mst(ev_mst), .ev_len(ev_len), .ev_press(ev_press),
        .ev_lat(ev_lat), .ext_flt(ext_flt), .req_evt(req_evt),
        .rsp_evt(rsp_evt), .ext_evt(ext_evt), .gen(gen_q), .sen(sen_q),
        .op(op_q), .isel(isel_q), .ext_sel(ext_sel_q), .mask(mask_q),
        .cmp(cmp_q), .wmin(wmin_q), .wmax(wmax_q), .inc(inc_w)
    );

    stat_tally_accum #(.CNT_W(CNT_W), .PER_W(PER_W), .INC_W(INC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .run(run_q), .manual(manual_q),
        .period(period_q), .send_q(send_q), .inc(inc_w), .dump_o(dump_w),
        .cnt_o(cnt_w), .frame_valid(frame_valid), .frame_data(frame_data)
    );

endmodule

// File: rtl/stat_tally_chk.sv
// Checker for stat_tally. It looks at the register outputs, the dump
// decision and the counter across the module boundaries, and is
// attached to the top module by the bind below.
module stat_tally_chk #(
    parameter int CNT_W = 32,
    parameter int PER_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             manual,
    input logic [PER_W-1:0] period,
    input logic             send_q,
    input logic             dump,
    input logic [CNT_W-1:0] cnt,
    input logic             frame_valid
);

    // R9: a frame needs either a running non-zero period or a manual send.
    a_r9_frame_source: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> ($past(send_q) && $past(manual)) ||
                        ($past(run) && !$past(manual) && ($past(period) != '0)));

    // R11: in manual mode the only frames come from the send strobe.
    a_r11_manual_only_send: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(manual) && frame_valid) |-> $past(send_q));

    // R12: between dumps the counter never decreases.
    a_r12_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !$past(dump)) |-> (cnt >= $past(cnt)));

    // R12: a saturated counter stays saturated until a dump.
    a_r12_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cnt) == '1) && !$past(dump)) |-> (cnt == '1));

    // R13: with run cleared and no dump, the counter holds.
    a_r13_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(run) && !$past(dump)) |-> $stable(cnt));

endmodule

bind stat_tally stat_tally_chk #(.CNT_W(CNT_W), .PER_W(PER_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run_q), .manual(manual_q),
    .period(period_q), .send_q(send_q), .dump(dump_w), .cnt(cnt_w),
    .frame_valid(frame_valid)
);

// File: tb/stat_tally_tb.sv
module stat_tally_tb;

    localparam int CNT_W = 16;
    localparam int INFO_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [3:0]        cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic              ev_valid = 1'b0, ev_rd = 1'b0, ev_wr = 1'b0, ev_err = 1'b0;
    logic [7:0]        ev_mst = '0;
    logic [INFO_W-1:0] ev_len = '0, ev_press = '0, ev_lat = '0;
    logic [3:0]        ext_flt = '0, req_evt = '0, rsp_evt = '0;
    logic [7:0]        ext_evt = '0;
    logic              frame_valid;
    logic [CNT_W-1:0]  frame_data;

    int total = 0;
    int bad = 0;

    stat_tally #(.CNT_W(CNT_W)) u_dut (.*);

    always #5 clk = ~clk;

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  isel;
        logic        rd, wr, err;
        logic [7:0]  mst;
        logic [11:0] len, press, lat;
        logic [3:0]  flt, req, rsp;
        logic [7:0]  ext;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VT [NV] = '{
        '{4'd0, 2'd0, 1'b1, 1'b0, 1'b0, 8'hA5, 12'd0, 12'd0, 12'd0, 4'h0, 4'h0, 4'h0, 8'h00, 16'd1},
        '{4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'hA5, 12'd0, 12'd0, 12'd0, 4'h0, 4'h0, 4'h0, 8'h00, 16'd0},
        '{4'd0, 2'd0, 1'b1, 1'b0, 1'b0, 8'hB0, 12'd0, 12'd0, 12'd0, 4'h0, 4'h0, 4'h0, 8'h00, 16'd0},
        '{4'd0, 2'd0, 1'b1, 1'b1, 1'b1, 8'hAF, 12'd0, 12'd0, 12'd0, 4'h0, 4'h0, 4'h0, 8'h00, 16'd1},
        '{4'd1, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 12'd100, 12'd0, 12'd0, 4'h0, 4'h0, 4'h0, 8'h00, 16'd1},
        '{4'd1, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 12'd201, 12'd150, 12'd150, 4'h0, 4'h0, 4'h0, 8'h00, 16'd0},
        '{4'd1, 2'd1, 1'b0, 1'b0, 1'b0, 8'h00, 12'd0, 12'd200, 12'd0, 4'h0, 4'h0, 4'h0, 8'h00, 16'd1},
        '{4'd1, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00, 12'd150, 12'd150, 12'd99, 4'h0, 4'h0, 4'h0, 8'h00, 16'd0},
        '{4'd2, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00, 12'd5, 12'd9, 12'd300, 4'h0, 4'h0, 4'h0, 8'h00, 16'd300},
        '{4'd2, 2'd1, 1'b0, 1'b0, 1'b0, 8'h00, 12'd5, 12'd7, 12'd300, 4'h0, 4'h0, 4'h0, 8'h00, 16'd7},
        '{4'd3, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 12'd0, 12'd0, 12'd0, 4'hF, 4'h0, 4'h0, 8'h00, 16'd1},
        '{4'd3, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 12'd0, 12'd0, 12'd0, 4'h7, 4'h0, 4'h0, 8'h00, 16'd0},
        '{4'd4, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 12'd0, 12'd0, 12'd0, 4'h4, 4'h0, 4'h0, 8'h00, 16'd1},
        '{4'd4, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 12'd0, 12'd0, 12'd0, 4'h0, 4'hF, 4'hF, 8'hFF, 16'd0},
        '{4'd5, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 12'd0, 12'd0, 12'd0, 4'h0, 4'hB, 4'h1, 8'h00, 16'd3},
        '{4'd6, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 12'd0, 12'd0, 12'd0, 4'h0, 4'h1, 4'h7, 8'h00, 16'd3},
        '{4'd7, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 12'd0, 12'd0, 12'd0, 4'h0, 4'hF, 4'h1, 8'h00, 16'd5},
        '{4'd8, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 12'd0, 12'd0, 12'd0, 4'h0, 4'h0, 4'h0, 8'h04, 16'd1},
        '{4'd8, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00, 12'd0, 12'd0, 12'd0, 4'hF, 4'hF, 4'hF, 8'hFB, 16'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the following posedge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Strobe SEND; the frame appears after the next posedge.
    task automatic send(input bit do_chk, input string tag, input logic [31:0] exp);
        wr(4'd3, 32'd1);
        @(negedge clk);
        if (do_chk) begin
            chk({tag, " frame_valid"}, 32'(frame_valid), 32'd1);
            chk({tag, " frame_data"}, 32'(frame_data), exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        chk(tag, cfg_rdata, exp);
    endtask

    task automatic idle_ev();
        ev_valid = 0; ev_rd = 0; ev_wr = 0; ev_err = 0; ev_mst = '0;
        ev_len = '0; ev_press = '0; ev_lat = '0;
        ext_flt = '0; req_evt = '0; rsp_evt = '0; ext_evt = '0;
    endtask

    function automatic string op_tag(input logic [3:0] op);
        case (op)
            4'd0: return "R2";
            4'd1: return "R4";
            4'd2: return "R5";
            4'd3, 4'd4: return "R6";
            4'd5, 4'd6, 4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Count frames over n cycles.
    task automatic count_frames(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (frame_valid) cnt++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int nf;
        int gap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and write/read
        chk("R1 frame_valid after reset", 32'(frame_valid), 32'd0);
        rd_chk("R1 CTRL reset", 4'd0, 32'd0);
        rd_chk("R1 WIN reset", 4'd6, 32'd0);
        rd_chk("R1 PERIOD reset", 4'd2, 32'd0);
        wr(4'd6, 32'd100 | (32'd200 << 16));
        rd_chk("R1 WIN readback", 4'd6, 32'h00C8_0064);

        wr(4'd0, 32'hF);
        wr(4'd4, 32'h0000_F001);
        wr(4'd5, 32'h0000_A001);
        rd_chk("R1 MASK readback", 4'd4, 32'h0000_F001);

        // Operation table (R2, R4..R8), manual mode, run on.
        for (int v = 0; v < NV; v++) begin
            wr(4'd1, 32'(VT[v].op) | (32'(VT[v].isel) << 4) | (32'd2 << 8));
            send(1'b0, "", 32'd0);
            ev_valid = 1'b1; ev_rd = VT[v].rd; ev_wr = VT[v].wr; ev_err = VT[v].err;
            ev_mst = VT[v].mst; ev_len = VT[v].len; ev_press = VT[v].press;
            ev_lat = VT[v].lat; ext_flt = VT[v].flt; req_evt = VT[v].req;
            rsp_evt = VT[v].rsp; ext_evt = VT[v].ext;
            @(negedge clk);
            idle_ev();
            send(1'b1, $sformatf("%s vec%0d", op_tag(VT[v].op), v), 32'(VT[v].exp));
        end

        // R3: each filter enable blocks a hit on its own.
        wr(4'd1, 32'd0);
        for (int k = 0; k < 2; k++) begin
            wr(4'd0, k == 0 ? 32'hB : 32'h7);
            send(1'b0, "", 32'd0);
            ev_valid = 1'b1; ev_rd = 1'b1; ev_mst = 8'hA5;
            @(negedge clk);
            idle_ev();
            send(1'b1, k == 0 ? "R3 global off" : "R3 stage off", 32'd0);
        end

        // R9: periodic dump every 5 cycles, steady frames carry 5.
        wr(4'd1, 32'd4);
        ext_flt = 4'h1;
        wr(4'd0, 32'hD);
        wr(4'd2, 32'd5);
        nf = 0;
        for (int i = 0; i < 20 && nf == 0; i++) begin
            @(negedge clk);
            if (frame_valid) nf = 1;
        end
        chk("R9 first periodic frame seen", 32'(nf), 32'd1);
        for (int r = 0; r < 2; r++) begin
            gap = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                gap++;
                if (frame_valid) break;
            end
            chk("R9 frame spacing", 32'(gap), 32'd5);
            chk("R10 periodic frame value", 32'(frame_data), 32'd5);
        end

        // R9: period 0 gives no frames.
        wr(4'd2, 32'd0);
        @(negedge clk);
        count_frames(20, nf);
        chk("R9 period zero frames", 32'(nf), 32'd0);

        // R11: manual stops periodic frames.
        wr(4'd2, 32'd5);
        wr(4'd0, 32'hF);
        @(negedge clk);
        count_frames(20, nf);
        chk("R11 manual no periodic", 32'(nf), 32'd0);

        // R10: back-to-back sends, counter restarts from increment.
        send(1'b0, "", 32'd0);
        send(1'b1, "R10 restart from increment", 32'd2);
        @(negedge clk);
        chk("R11 single frame per send", 32'(frame_valid), 32'd0);
        rd_chk("R11 SEND self-clears", 4'd3, 32'd0);

        // R13: run off, counter stays 0.
        wr(4'd0, 32'hE);
        send(1'b0, "", 32'd0);
        repeat (4) @(negedge clk);
        send(1'b1, "R13 run off no count", 32'd0);

        // R12: saturation with 4095 per cycle.
        ext_flt = '0;
        wr(4'd0, 32'hF);
        wr(4'd1, 32'd2);
        ev_valid = 1'b1; ev_len = 12'd4095;
        repeat (20) @(negedge clk);
        idle_ev();
        send(1'b1, "R12 saturate", 32'hFFFF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule